// File: doc/BRIEF.md
# Clock Calibration Prescaler

This block turns a stream of oscillator ticks at 32,768 per second into a one-cycle pulse once per second for a timekeeping chain. It corrects a fast or slow crystal digitally: it trims whole counts out of the divider instead of pulling the oscillator. The trim happens at the stage that divides by 256. A 64-minute correction cycle runs alongside the divider, driven by a minute-boundary strobe from the calendar counters. In the first 2×N minutes of each cycle, one second per minute is made shorter or longer. N is the 5-bit calibration magnitude.

A sign input picks the direction. A positive setting ends the adjusted second 256 oscillator ticks early (the clock gains time). A negative setting ends it 128 ticks late (the clock loses time). A stop input freezes and clears the divider. A test enable puts out a square wave at 1/64 of the oscillator rate (512 Hz). This wave is taken from a counter that the correction never touches.

The adjustment is sequenced by a five-state machine:
- HALT is entered on reset and whenever stop is high. It moves to PLAIN once stop is low.
- PLAIN means the current second is unadjusted. An accepted minute boundary that requests correction moves it to PEND, or to ADJ if the boundary lands on a second's end.
- PEND means a correction is waiting. The next second end moves it to ADJ. A later boundary with no request returns it to PLAIN.
- ADJ means the current second is adjusted. Its end returns to PLAIN, or stays in ADJ if a requesting boundary coincides. A requesting boundary in mid-second moves it to ADJ_PEND.
- ADJ_PEND means the current second is adjusted and the next one will be too. Its end moves to ADJ. A non-requesting boundary drops it back to ADJ.

Top module: `clk_cal_prescaler`

## Requirements
- R1: With no correction in force, every second is exactly 2^SEC_W oscillator ticks long (32,768 by default). `sec_tick` is high for one clock, in the cycle after the clock edge that samples the tick completing the second.
- R2: An adjusted second with `cal_pos` = 1 is exactly 2^PRE_W ticks (256) shorter than nominal.
- R3: An adjusted second with `cal_pos` = 0 is exactly 2^(PRE_W-1) ticks (128) longer than nominal.
- R4: `cal_minute` reads 63 after reset. It advances by one, wrapping 63 to 0, on each accepted `minute_edge`. A boundary that opens minute index k requests correction exactly when k < 2×`cal_mag`, so at most indices 0 to 61 are ever adjusted.
- R5: A `cal_mag` of 0 gives nominal seconds in every minute, whatever `cal_pos` is.
- R6: `cal_mag` and `cal_pos` are sampled only on the boundary cycle; later changes have no effect on that minute. The second in progress at the boundary keeps its length. The second that starts next is the one adjusted, and only that one in the minute.
- R7: While `stop` is 1, no `sec_tick` is produced and `minute_edge` is ignored (`cal_minute` holds).
- R8: After `stop` falls, the divider restarts from zero: the first `sec_tick` comes exactly 2^SEC_W ticks later.
- R9: `ft_wave` is a square wave with a period of 2^FT_W ticks (64 by default, so 512 Hz). It equals bit FT_W-1 of the number of ticks since the divider last restarted. It is 0 whenever `ft_en` is 0 or `stop` is 1.
- R10: `ft_wave` is identical whatever the calibration setting and whether a second is being adjusted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator period |
| cal_mag | input | MAG_W | Calibration magnitude N, 0 to 31 |
| cal_pos | input | 1 | Sign: 1 shortens seconds, 0 lengthens them |
| stop | input | 1 | 1 freezes and clears the divider |
| ft_en | input | 1 | Enables the test square wave |
| minute_edge | input | 1 | One-cycle strobe at each minute boundary |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| cal_minute | output | MIN_W | Index of the current minute in the 64-minute cycle |
| ft_wave | output | 1 | Uncorrected test square wave |

## Verification
The assertions check these on every cycle:
- `sec_tick` follows an oscillator tick and never lasts two cycles.
- `stop` silences the second pulse one cycle later.
- `cal_minute` moves only on an accepted boundary, and then by exactly one.
- `ft_wave` changes only after a tick unless its controls moved.

Only the bench scenarios can show the exact length of each second. That covers which minute indices are adjusted, the one-second delay after a boundary, boundary-time sampling of the magnitude and sign, restart timing after stop, and the test wave's phase across an adjusted second.

// File: rtl/clk_cal_pkg.sv
package clk_cal_pkg;

    typedef enum logic [2:0] {
        SQ_HALT,
        SQ_PLAIN,
        SQ_PEND,
        SQ_ADJ,
        SQ_ADJ_PEND
    } seq_state_e;

    localparam int CYCLE_MINUTES = 64;

endpackage

// File: rtl/clk_cal_fine.sv
// Lowest divider stage: counts oscillator ticks in groups of 2^PRE_W.
// When stretch is high the group is half as long again (negative trim).
module clk_cal_fine #(
    parameter int PRE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic osc_tick,
    input  logic stretch,
    output logic pre_stb
);
    localparam int CNT_W = PRE_W + 1;
    localparam logic [CNT_W-1:0] BASE_TERM = CNT_W'(2**PRE_W - 1);
    localparam logic [CNT_W-1:0] LONG_TERM = CNT_W'(2**PRE_W + 2**(PRE_W-1) - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] term;

    always_comb begin
        term    = stretch ? LONG_TERM : BASE_TERM;
        pre_stb = run && osc_tick && (cnt >= term);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (osc_tick) begin
            cnt <= pre_stb ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/clk_cal_coarse.sv
// Upper divider stage: counts prescaler strobes up to one second.
// When skip is high one strobe period is dropped (positive trim).
module clk_cal_coarse #(
    parameter int HI_W = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic pre_stb,
    input  logic skip,
    output logic last,
    output logic sec_end
);
    localparam logic [HI_W-1:0] FULL_TERM  = HI_W'(2**HI_W - 1);
    localparam logic [HI_W-1:0] SHORT_TERM = HI_W'(2**HI_W - 2);

    logic [HI_W-1:0] hi;
    logic [HI_W-1:0] term;

    always_comb begin
        term    = skip ? SHORT_TERM : FULL_TERM;
        last    = (hi >= term);
        sec_end = pre_stb && last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi <= '0;
        end else if (!run) begin
            hi <= '0;
        end else if (pre_stb) begin
            hi <= sec_end ? '0 : hi + 1'b1;
        end
    end
endmodule

// File: rtl/clk_cal_testwave.sv
// Free-running uncorrected counter giving the test square wave.
module clk_cal_testwave #(
    parameter int FT_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic osc_tick,
    input  logic ft_en,
    output logic ft_wave
);
    logic [FT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (osc_tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ft_wave = ft_en && run && cnt[FT_W-1];
endmodule

// File: rtl/clk_cal_seq.sv
// Correction sequencer: tracks the minute index, decides per minute whether
// a second is trimmed, and selects which second carries the trim.
module clk_cal_seq
    import clk_cal_pkg::*;
#(
    parameter int MAG_W = 5,
    parameter int MIN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             minute_edge,
    input  logic [MAG_W-1:0] cal_mag,
    input  logic             cal_pos,
    input  logic             sec_end,
    output logic             skip,
    output logic             stretch_arm,
    output logic [MIN_W-1:0] cal_minute,
    output logic             sec_tick
);
    seq_state_e state, state_nx;

    logic [MIN_W-1:0] next_idx;
    logic             edge_ok;
    logic             want;
    logic             req_pos;
    logic             act_pos;
    logic             adjusting;

    always_comb begin
        next_idx = cal_minute + {{(MIN_W-1){1'b0}}, 1'b1};
        edge_ok  = minute_edge && run;
        want     = (cal_mag != '0) && (int'(next_idx) < 2 * int'(cal_mag));
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_HALT: begin
                state_nx = SQ_PLAIN;
            end
            SQ_PLAIN: begin
                if (edge_ok && want) begin
                    state_nx = sec_end ? SQ_ADJ : SQ_PEND;
                end
            end
            SQ_PEND: begin
                if (edge_ok) begin
                    if (!want)        state_nx = SQ_PLAIN;
                    else if (sec_end) state_nx = SQ_ADJ;
                end else if (sec_end) begin
                    state_nx = SQ_ADJ;
                end
            end
            SQ_ADJ: begin
                if (sec_end) begin
                    state_nx = (edge_ok && want) ? SQ_ADJ : SQ_PLAIN;
                end else if (edge_ok && want) begin
                    state_nx = SQ_ADJ_PEND;
                end
            end
            SQ_ADJ_PEND: begin
                if (sec_end) begin
                    state_nx = (edge_ok && !want) ? SQ_PLAIN : SQ_ADJ;
                end else if (edge_ok && !want) begin
                    state_nx = SQ_ADJ;
                end
            end
            default: state_nx = SQ_HALT;
        endcase
        if (!run) state_nx = SQ_HALT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_HALT;
        else        state <= state_nx;
    end

    // minute index and sampled sign
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_minute <= '1;
            req_pos    <= 1'b0;
            act_pos    <= 1'b0;
        end else begin
            if (edge_ok) begin
                cal_minute <= next_idx;
                req_pos    <= cal_pos;
            end
            if (sec_end && state_nx == SQ_ADJ) begin
                act_pos <= edge_ok ? cal_pos : req_pos;
            end
        end
    end

    // outputs
    always_comb begin
        adjusting   = (state == SQ_ADJ) || (state == SQ_ADJ_PEND);
        skip        = adjusting && act_pos;
        stretch_arm = adjusting && !act_pos;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sec_tick <= 1'b0;
        else        sec_tick <= sec_end;
    end
endmodule

// File: rtl/clk_cal_prescaler.sv
module clk_cal_prescaler #(
    parameter int PRE_W = 8,
    parameter int SEC_W = 15,
    parameter int MAG_W = 5,
    parameter int MIN_W = 6,
    parameter int FT_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic [MAG_W-1:0] cal_mag,
    input  logic             cal_pos,
    input  logic             stop,
    input  logic             ft_en,
    input  logic             minute_edge,
    output logic             sec_tick,
    output logic [MIN_W-1:0] cal_minute,
    output logic             ft_wave
);
    localparam int HI_W = SEC_W - PRE_W;

    logic run;
    logic pre_stb;
    logic last;
    logic sec_end;
    logic cal_skip;
    logic stretch_arm;
    logic cal_stretch;

    assign run         = !stop;
    assign cal_stretch = stretch_arm && last;

    clk_cal_fine #(.PRE_W(PRE_W)) u_fine (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .osc_tick (osc_tick),
        .stretch  (cal_stretch),
        .pre_stb  (pre_stb)
    );

    clk_cal_coarse #(.HI_W(HI_W)) u_coarse (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .pre_stb (pre_stb),
        .skip    (cal_skip),
        .last    (last),
        .sec_end (sec_end)
    );

    clk_cal_seq #(.MAG_W(MAG_W), .MIN_W(MIN_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .minute_edge (minute_edge),
        .cal_mag     (cal_mag),
        .cal_pos     (cal_pos),
        .sec_end     (sec_end),
        .skip        (cal_skip),
        .stretch_arm (stretch_arm),
        .cal_minute  (cal_minute),
        .sec_tick    (sec_tick)
    );

    clk_cal_testwave #(.FT_W(FT_W)) u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .osc_tick (osc_tick),
        .ft_en    (ft_en),
        .ft_wave  (ft_wave)
    );
endmodule

// File: rtl/clk_cal_prescaler_chk.sv
module clk_cal_prescaler_chk #(
    parameter int MIN_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             osc_tick,
    input logic             stop,
    input logic             ft_en,
    input logic             minute_edge,
    input logic             sec_tick,
    input logic             ft_wave,
    input logic [MIN_W-1:0] cal_minute
);
    // R1: a second ends only on an oscillator tick
    a_r1_tick_after_osc: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> $past(osc_tick));

    // R1: the pulse is one clock wide
    a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

    // R7: stop silences the second pulse
    a_r7_stop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !sec_tick);

    // R4: accepted boundary advances the index by one
    a_r4_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        (minute_edge && !stop) |=> (cal_minute == MIN_W'($past(cal_minute) + 1'b1)));

    // R4 / R7: no accepted boundary, no index change
    a_r4_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!minute_edge || stop) |=> $stable(cal_minute));

    // R10: the test wave moves only on oscillator ticks
    a_r10_wave_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ft_wave) && $stable(ft_en) && $stable(stop)) |-> $past(osc_tick));
endmodule

bind clk_cal_prescaler clk_cal_prescaler_chk #(.MIN_W(MIN_W)) u_chk (.*);

// File: tb/tb_clk_cal_prescaler.sv
module tb_clk_cal_prescaler;
    localparam int PRE_W = 4;
    localparam int SEC_W = 8;
    localparam int FT_W  = 3;
    localparam int NOM   = 2**SEC_W;
    localparam int POSL  = NOM - 2**PRE_W;
    localparam int NEGL  = NOM + 2**(PRE_W-1);

    typedef struct packed {
        int idx;
        int mag;
        int pos;
        int len;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{0,  1,  1, POSL},
        '{1,  1,  1, POSL},
        '{2,  1,  1, NOM},
        '{3,  6,  0, NEGL},
        '{11, 6,  0, NEGL},
        '{12, 6,  0, NOM},
        '{20, 0,  1, NOM},
        '{61, 31, 1, POSL},
        '{62, 31, 0, NOM},
        '{63, 31, 1, NOM},
        '{0,  31, 0, NEGL}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic [4:0] cal_mag = '0;
    logic       cal_pos = 1'b0;
    logic       stop = 1'b0;
    logic       ft_en = 1'b0;
    logic       minute_edge = 1'b0;
    logic       sec_tick;
    logic [5:0] cal_minute;
    logic       ft_wave;

    int checks = 0;
    int fails = 0;
    int n_secs = 0;
    int last_len = 0;
    int cnt = 0;
    int run_ticks = 0;
    int phase = 0;
    int exp_idx = 63;

    always #2 clk = ~clk;

    clk_cal_prescaler #(.PRE_W(PRE_W), .SEC_W(SEC_W), .FT_W(FT_W)) dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cal_mag(cal_mag),
        .cal_pos(cal_pos), .stop(stop), .ft_en(ft_en),
        .minute_edge(minute_edge), .sec_tick(sec_tick),
        .cal_minute(cal_minute), .ft_wave(ft_wave)
    );

    // tick generator and second-length monitor
    always @(negedge clk) begin
        if (sec_tick) begin
            last_len = cnt;
            cnt = 0;
            n_secs++;
        end
        if (!rst_n || stop) begin
            cnt = 0;
            run_ticks = 0;
        end
        if (phase == 0) begin
            osc_tick = 1'b1;
            if (rst_n && !stop) begin
                cnt++;
                run_ticks++;
            end
        end else begin
            osc_tick = 1'b0;
        end
        phase = (phase + 1) % 4;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_sec();
        int s0;
        s0 = n_secs;
        while (n_secs == s0) step();
    endtask

    task automatic pulse_edge();
        minute_edge = 1'b1;
        step();
        minute_edge = 1'b0;
        step();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        ft_en = 1'b1;
        repeat (4) step();
        chk(sec_tick == 1'b0, "R1 reset sec_tick", sec_tick, 0);
        chk(cal_minute == 6'd63, "R4 reset index", cal_minute, 63);
        chk(ft_wave == 1'b0, "R9 reset wave", ft_wave, 0);
        ft_en = 1'b0;
        rst_n = 1'b1;

        wait_sec();
        chk(last_len == NOM, "R1 first second", last_len, NOM);
        wait_sec();
        chk(last_len == NOM, "R1 nominal second", last_len, NOM);

        for (int v = 0; v < NV; v++) begin
            string tag;
            int d;
            wait_sec();
            d = (VECS[v].idx - exp_idx + 64) % 64;
            cal_mag = '0;
            for (int k = 0; k < d - 1; k++) pulse_edge();
            cal_mag = 5'(VECS[v].mag);
            cal_pos = VECS[v].pos[0];
            pulse_edge();
            exp_idx = VECS[v].idx;
            // R6: changes after the boundary must not matter
            cal_mag = 5'd0;
            cal_pos = ~cal_pos;
            chk(cal_minute == 6'(exp_idx), "R4 minute index", cal_minute, exp_idx);
            wait_sec();
            chk(last_len == NOM, "R6 second in progress", last_len, NOM);
            wait_sec();
            if (VECS[v].mag == 0)         tag = "R5 zero magnitude";
            else if (VECS[v].len == POSL) tag = "R2 shortened second";
            else if (VECS[v].len == NEGL) tag = "R3 stretched second";
            else                          tag = "R4 minute outside window";
            chk(last_len == VECS[v].len, tag, last_len, VECS[v].len);
            wait_sec();
            chk(last_len == NOM, "R6 one second per minute", last_len, NOM);
        end

        // stop behaviour
        begin
            int s0;
            wait_sec();
            stop = 1'b1;
            ft_en = 1'b1;
            s0 = n_secs;
            repeat (10) step();
            chk(ft_wave == 1'b0, "R9 wave while stopped", ft_wave, 0);
            pulse_edge();
            chk(cal_minute == 6'(exp_idx), "R7 edge ignored", cal_minute, exp_idx);
            repeat (2000) step();
            chk(n_secs == s0, "R7 no ticks while stopped", n_secs, s0);
            stop = 1'b0;
            wait_sec();
            chk(last_len == NOM, "R8 restart length", last_len, NOM);
        end

        // test wave across an adjusted second
        begin
            int bad;
            int s0;
            bit saw_pos;
            bad = 0;
            saw_pos = 1'b0;
            cal_mag = 5'd31;
            cal_pos = 1'b1;
            pulse_edge();
            exp_idx = (exp_idx + 1) % 64;
            s0 = n_secs;
            for (int c = 0; c < 3500; c++) begin
                step();
                if (ft_wave != 1'((run_ticks >> (FT_W - 1)) & 1)) bad++;
                if (n_secs != s0) begin
                    s0 = n_secs;
                    if (last_len == POSL) saw_pos = 1'b1;
                end
            end
            chk(bad == 0, "R9 R10 wave phase", bad, 0);
            chk(saw_pos, "R2 trim during wave test", saw_pos, 1);
            ft_en = 1'b0;
            bad = 0;
            for (int c = 0; c < 40; c++) begin
                step();
                if (ft_wave) bad++;
            end
            chk(bad == 0, "R9 wave disabled", bad, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule